// File: doc/BRIEF.md
# Non-Nesting Prioritized Interrupt Arbiter

This block chooses which interrupt a processor services next. It watches four asynchronous process interrupt lines (A, B, C, D), four synchronous timed-interrupt request pulses, and one special timer request pulse. Each source has one single-deep pending flag. A process line sets its flag on a rising edge. The edge is taken through a two-flop synchronizer, and edges that come closer together than a minimum spacing are merged into one. A timed or special request sets its flag on a one-cycle pulse.

When the processor signals an instruction boundary and no handler is running, the arbiter takes the highest-ranked pending source and clears its flag. It then registers that source's handler vector and raises `valid` and `busy`. It holds them until the processor reports that the handler is complete. Service never nests: requests that arrive during a handler are only stored, and they are dispatched one per boundary after the handler ends.

The controlling state machine `irq_serve_fsm` has two states:
- `ST_IDLE`: no handler is running.
- `ST_SERVE`: a handler is running.

It has three transitions:
- LAUNCH (`ST_IDLE` to `ST_SERVE`): a boundary strobe arrives with a pending winner whose handler is enabled.
- DROP (`ST_IDLE` to `ST_IDLE`): a boundary strobe arrives with a pending winner whose handler is disabled. The winner's flag is cleared and nothing starts.
- RELEASE (`ST_SERVE` to `ST_IDLE`): the done strobe arrives.

Top module: `irq_arbiter`

## Requirements
- R1: Source index and vector mapping:
  - Index 0 to 3 are lines A to D, with vectors 2, 3, 4, 5.
  - Index 4 is the special timer, with vector 6.
  - Index 5 to 8 are timed requests 0 to 3, with vectors 10, 11, 12, 13.
  - Bit i of `hdl_en` and of `tmr_req` follows this indexing. `tmr_req[k]` is index 5+k.
- R2: With `spec_first`=0, the rank from highest to lowest is A, B, C, D, special, timed 0, timed 1, timed 2, timed 3.
- R3: With `spec_first`=1, the special timer ranks above A. The rest of the order is unchanged.
- R4: While `busy` is high and `done` is low, `busy`, `valid` and `vec` stay unchanged, whatever requests or boundary strobes arrive.
- R5: A service starts only when `boundary` is sampled high while idle. `valid`, `busy` and `vec` update at the next clock edge. Pending requests with no boundary strobe produce no service.
- R6: `done` sampled high while busy drops `valid` and `busy` on the following edge.
- R7: Each source stores at most one request. Several spaced edges on one line during a handler produce exactly one later service.
- R8: An edge on a line arriving less than `GAP_NS` (12 µs by default; `CLK_KHZ`*`GAP_NS`/10^6 cycles) after that line's last accepted edge is merged and produces no request.
- R9: Stored requests are dispatched one per boundary strobe, in rank order. A boundary strobe with nothing pending starts nothing.
- R10: If the winner's `hdl_en` bit is 0, that request is cleared at the boundary and no service starts. The next boundary strobe serves the next pending source.
- R11: A synchronous active-high `rst` clears all pending flags, spacing counters and outputs.
- R12: A line held high counts as one request only; a level alone never re-requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_raw | input | 4 | Asynchronous process interrupt lines, bit 0 = A .. bit 3 = D |
| tmr_req | input | 4 | Timed-interrupt request pulses, bit k = timed k (vector 10+k) |
| spec_req | input | 1 | Special timer request pulse (vector 6) |
| spec_first | input | 1 | 1: special timer ranks above A; 0: below D |
| boundary | input | 1 | Instruction-boundary strobe |
| done | input | 1 | Handler completion strobe |
| hdl_en | input | 9 | Handler present per source index |
| vec | output | 4 | Vector of the source in service |
| valid | output | 1 | Vector valid, held until done |
| busy | output | 1 | Handler in service |

## Verification
The hardest state to reach is a handler in progress while several stored requests pile up behind it. This includes repeated edges on one line that must collapse to a single request, and edges inside the spacing window that must vanish. The bench holds a handler open by withholding `done`, and meanwhile drives spaced edges, timed pulses and a special pulse. It then drains the queue one boundary at a time. A sweep over every subset of the nine sources, under both rank settings, fills the pending flags together and checks the full dispatch order against a rank computed in the bench.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NUM_LINES = 4;
    localparam int NUM_TMR   = 4;
    localparam int NUM_SRC   = NUM_LINES + 1 + NUM_TMR;
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int VEC_W     = 4;
    localparam int SPEC_IDX  = NUM_LINES;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } serve_state_e;

    // Handler vector of a source index.
    function automatic logic [VEC_W-1:0] src_vector(input logic [SRC_W-1:0] idx);
        logic [VEC_W-1:0] v;
        if (int'(idx) < NUM_LINES)
            v = VEC_W'(int'(idx) + 2);
        else if (int'(idx) == SPEC_IDX)
            v = VEC_W'(6);
        else
            v = VEC_W'(int'(idx) + 5);
        return v;
    endfunction

    // Source index occupying a rank position (0 = highest).
    function automatic int rank_to_src(input int pos, input logic spec_hi);
        int s;
        if (spec_hi) begin
            if (pos == 0)
                s = SPEC_IDX;
            else if (pos <= NUM_LINES)
                s = pos - 1;
            else
                s = pos;
        end else begin
            s = pos;
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
    parameter int GAP_CYCLES = 2400
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic clr,
    output logic pend
);
    localparam int CNT_W = (GAP_CYCLES > 0) ? $clog2(GAP_CYCLES + 1) : 1;

    logic             sync_a;
    logic             sync_b;
    logic             last_lvl;
    logic [CNT_W-1:0] hold_cnt;
    logic             rise;
    logic             accept;

    assign rise   = sync_b & ~last_lvl;
    assign accept = rise & (hold_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            last_lvl <= 1'b0;
        end else begin
            sync_a   <= raw;
            sync_b   <= sync_a;
            last_lvl <= sync_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_cnt <= '0;
        else if (accept)
            hold_cnt <= CNT_W'(GAP_CYCLES);
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    // A fresh request wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (accept)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end

endmodule

// File: rtl/irq_pulse_latch.sv
module irq_pulse_latch #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] pend
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[g] <= 1'b0;
            else if (req[g])
                pend[g] <= 1'b1;
            else if (clr[g])
                pend[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic               spec_first,
    output logic               any,
    output logic [SRC_W-1:0]   win_idx
);
    always_comb begin
        win_idx = '0;
        // Walk from lowest rank upward so the highest pending rank is kept.
        for (int p = NUM_SRC - 1; p >= 0; p--) begin
            if (pend[rank_to_src(p, spec_first)])
                win_idx = SRC_W'(rank_to_src(p, spec_first));
        end
        any = |pend;
    end

endmodule

// File: rtl/irq_serve_fsm.sv
module irq_serve_fsm
    import irq_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary,
    input  logic               done,
    input  logic               any,
    input  logic [SRC_W-1:0]   win_idx,
    input  logic [NUM_SRC-1:0] hdl_en,
    output logic [NUM_SRC-1:0] clr,
    output logic [VEC_W-1:0]   vec,
    output logic               valid,
    output logic               busy
);
    serve_state_e state_q;
    serve_state_e state_d;
    logic         pick;
    logic         launch;

    assign pick   = (state_q == ST_IDLE) && boundary && any;
    assign launch = pick && hdl_en[win_idx];
    assign clr    = pick ? (NUM_SRC'(1) << win_idx) : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_SERVE;
            ST_SERVE: if (done)   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec   <= '0;
            valid <= 1'b0;
            busy  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        vec   <= src_vector(win_idx);
                        valid <= 1'b1;
                        busy  <= 1'b1;
                    end
                end
                ST_SERVE: begin
                    if (done) begin
                        valid <= 1'b0;
                        busy  <= 1'b0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int CLK_KHZ = 200000,
    parameter int GAP_NS  = 12000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_raw,
    input  logic [NUM_TMR-1:0]   tmr_req,
    input  logic                 spec_req,
    input  logic                 spec_first,
    input  logic                 boundary,
    input  logic                 done,
    input  logic [NUM_SRC-1:0]   hdl_en,
    output logic [VEC_W-1:0]     vec,
    output logic                 valid,
    output logic                 busy
);
    localparam longint GAP_L      = (longint'(CLK_KHZ) * longint'(GAP_NS)) / 64'd1000000;
    localparam int     GAP_CYCLES = int'(GAP_L);

    logic [NUM_SRC-1:0] src_pend;
    logic [NUM_SRC-1:0] src_clr;
    logic               any;
    logic [SRC_W-1:0]   win_idx;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_capture #(.GAP_CYCLES(GAP_CYCLES)) u_cap (
            .clk  (clk),
            .rst  (rst),
            .raw  (irq_raw[g]),
            .clr  (src_clr[g]),
            .pend (src_pend[g])
        );
    end

    irq_pulse_latch #(.WIDTH(NUM_TMR + 1)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .req  ({tmr_req, spec_req}),
        .clr  (src_clr[NUM_SRC-1:NUM_LINES]),
        .pend (src_pend[NUM_SRC-1:NUM_LINES])
    );

    irq_prio_pick u_pick (
        .pend       (src_pend),
        .spec_first (spec_first),
        .any        (any),
        .win_idx    (win_idx)
    );

    irq_serve_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .done     (done),
        .any      (any),
        .win_idx  (win_idx),
        .hdl_en   (hdl_en),
        .clr      (src_clr),
        .vec      (vec),
        .valid    (valid),
        .busy     (busy)
    );

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
    import irq_arb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               boundary,
    input logic               done,
    input logic               valid,
    input logic               busy,
    input logic [VEC_W-1:0]   vec,
    input logic [NUM_SRC-1:0] clr
);
    assert_vec_legal_R1: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((vec >= 4'd2 && vec <= 4'd6) || (vec >= 4'd10 && vec <= 4'd13)));

    assert_no_preempt_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && valid && $stable(vec)));

    assert_start_on_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(boundary));

    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> (!busy && !valid));

    assert_one_dispatch_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));

    assert_no_clear_in_service_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (clr == '0));

endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .done     (done),
    .valid    (valid),
    .busy     (busy),
    .vec      (vec),
    .clr      (src_clr)
);

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] irq_raw = '0;
    logic [3:0] tmr_req = '0;
    logic       spec_req = 1'b0;
    logic       spec_first = 1'b0;
    logic       boundary = 1'b0;
    logic       done = 1'b0;
    logic [8:0] hdl_en = '1;
    logic [3:0] vec;
    logic       valid;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // 1 MHz setting: spacing window of 12 cycles.
    irq_arbiter #(.CLK_KHZ(1000), .GAP_NS(12000)) i_irq_arbiter (
        .clk(clk), .rst(rst), .irq_raw(irq_raw), .tmr_req(tmr_req),
        .spec_req(spec_req), .spec_first(spec_first), .boundary(boundary),
        .done(done), .hdl_en(hdl_en), .vec(vec), .valid(valid), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int vec_of(input int s);
        if (s < 4) return s + 2;
        if (s == 4) return 6;
        return s + 5;
    endfunction

    function automatic int src_at(input int p, input bit hi);
        if (!hi) return p;
        if (p == 0) return 4;
        if (p <= 4) return p - 1;
        return p;
    endfunction

    task automatic fire(input logic [3:0] lines, input logic [3:0] tm, input logic sp);
        irq_raw = lines; tmr_req = tm; spec_req = sp;
        cyc(1);
        tmr_req = '0; spec_req = 1'b0;
        cyc(1);
        irq_raw = '0;
        cyc(3);
    endtask

    task automatic serve(input int exp_vec, input string req);
        boundary = 1'b1;
        cyc(1);
        boundary = 1'b0;
        chk(valid && busy && int'(vec) == exp_vec, req, valid ? int'(vec) : -1, exp_vec);
        done = 1'b1;
        cyc(1);
        done = 1'b0;
        chk(!busy && !valid, "R6 release", int'(busy), 0);
    endtask

    task automatic nothing(input string req);
        boundary = 1'b1;
        cyc(1);
        boundary = 1'b0;
        chk(!valid && !busy, req, int'(valid), 0);
    endtask

    initial begin
        cyc(3);
        chk(!valid && !busy && vec == 4'd0, "R11 reset state", int'(vec), 0);
        rst = 1'b0;
        cyc(2);

        // R5: pending alone starts nothing
        fire(4'b0001, 4'b0000, 1'b0);
        cyc(10);
        chk(!valid && !busy, "R5 no boundary", int'(valid), 0);
        serve(2, "R5 start on boundary");
        nothing("R9 empty boundary");

        // R4, R7, R9: requests pile up during a handler
        cyc(20);
        fire(4'b0001, 4'b0000, 1'b0);
        boundary = 1'b1; cyc(1); boundary = 1'b0;
        chk(valid && vec == 4'd2, "R4 service open", int'(vec), 2);
        for (int t = 0; t < 60; t++) begin
            irq_raw[1] = ((t % 20) < 2);
            tmr_req[0] = (t == 5 || t == 25);
            spec_req   = (t == 30);
            boundary   = (t % 7 == 3);
            cyc(1);
            chk(valid && busy && vec == 4'd2, "R4 no preemption", int'(vec), 2);
        end
        irq_raw = '0; tmr_req = '0; spec_req = 1'b0; boundary = 1'b0;
        done = 1'b1; cyc(1); done = 1'b0;
        chk(!busy, "R6 release", int'(busy), 0);
        serve(3, "R7 R9 stored B first");
        serve(6, "R9 stored special next");
        serve(10, "R7 R9 stored timed 0 once");
        nothing("R7 single-deep");

        // R8: edge inside spacing window is merged
        cyc(20);
        irq_raw[2] = 1'b1; cyc(2); irq_raw[2] = 1'b0; cyc(1);
        serve(4, "R8 first edge");
        irq_raw[2] = 1'b1; cyc(2); irq_raw[2] = 1'b0;
        cyc(20);
        nothing("R8 close edge merged");
        irq_raw[2] = 1'b1; cyc(2); irq_raw[2] = 1'b0; cyc(3);
        serve(4, "R8 spaced edge accepted");

        // R10: disabled handler dropped
        cyc(20);
        hdl_en = 9'h1F7;
        fire(4'b1000, 4'b0001, 1'b0);
        nothing("R10 disabled line dropped");
        serve(10, "R10 next source served");
        nothing("R10 drained");
        hdl_en = '1;

        // R12: level held high counts once
        cyc(20);
        irq_raw[0] = 1'b1;
        cyc(5);
        serve(2, "R12 held line");
        cyc(30);
        nothing("R12 no re-request");
        irq_raw[0] = 1'b0;

        // R11: reset clears pending
        cyc(20);
        fire(4'b0010, 4'b0100, 1'b1);
        rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
        nothing("R11 pending cleared");

        // R1 R2 R3: every subset under both rank settings
        for (int hi = 0; hi < 2; hi++) begin
            spec_first = hi[0];
            for (int m = 1; m < 512; m++) begin
                logic [8:0] mk;
                mk = 9'(m);
                cyc(14);
                fire(mk[3:0], mk[8:5], mk[4]);
                for (int p = 0; p < 9; p++) begin
                    int s;
                    s = src_at(p, hi[0]);
                    if (mk[s]) serve(vec_of(s), hi ? "R1 R3 order" : "R1 R2 order");
                end
                nothing("R9 drained");
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule